// File: doc/BRIEF.md
# Interrupt Pin Acceptance and End-of-Interrupt Logic

This block takes a bank of interrupt input lines, each described by a routing entry that a register file elsewhere supplies. It turns assertions on those lines into delivery messages for a downstream interrupt controller. For each pin it applies a polarity inversion and keeps a request bit. The entry's trigger mode then decides whether a new delivery is due: edge pins fire once per rising request, and level pins fire once and then wait for an acknowledgement.

Acknowledgements arrive as end-of-interrupt (EOI) broadcasts that carry a vector. A broadcast releases every level-triggered entry with that vector, and such an entry is delivered again if its line is still active. The register file also signals when the low half of an entry has been rewritten. That signal releases the entry in the same way. Deliveries leave through a single valid/ready port, and when several pins are due at once the lowest-numbered pin goes first.

Top module: `irq_accept_eoi`

## Requirements
- R1: After synchronous reset, `dlv_valid` is low, and no delivery appears until a line becomes effectively active on an unmasked entry.
- R2: Entry `i` sits at bits `[23*i+22 : 23*i]` of `route_tbl`. Its bit 12 is the polarity bit, and the effective level is the raw pin XOR that bit. An inactive effective level clears the pin's request bit.
- R3: An entry with bit 13 = 0 is edge-triggered. It is delivered once each time its request bit goes from 0 to 1. A line held active, or re-asserted while its request bit is already set, gives no further delivery.
- R4: An entry with bit 13 = 1 is level-triggered. It is delivered while its request bit is set and its remote-pending flag is clear. Acceptance of that delivery sets remote-pending, and no further delivery follows while the flag stays set.
- R5: An entry with bit 14 = 1 is masked and is never delivered. A level request that arrives while masked is kept, and it is delivered once the mask is cleared.
- R6: An EOI (`eoi_valid` with `eoi_vector`) clears remote-pending on every level-triggered entry whose vector (bits 7:0) matches. If the line is still active, that entry is delivered again. An EOI with any other vector, or one aimed at an edge-triggered entry, produces no delivery.
- R7: A pulse on `route_rewr[i]` clears remote-pending of entry `i`. A level entry whose request bit is set is therefore delivered again without an EOI.
- R8: When several pins are due together, the lowest pin number is delivered first. The others stay pending and follow as the port accepts.
- R9: The delivery message carries the vector (bits 7:0), the delivery mode (bits 10:8), the destination mode (bit 11), the destination (bits 22:15) and the trigger mode (bit 13). It is held stable while `dlv_valid` is high and `dlv_ready` is low.
- R10: An EOI for a level entry that arrives in the same cycle as the acceptance of that entry's delivery leaves remote-pending set, so no redelivery follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 24 | Raw interrupt lines |
| route_tbl | input | 552 | Routing entries, 23 bits per pin |
| route_rewr | input | 24 | Per-pin strobe: the entry's low half was rewritten |
| eoi_valid | input | 1 | EOI broadcast present |
| eoi_vector | input | 8 | Vector carried by the EOI |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Downstream accepts the message |
| dlv_vector | output | 8 | Delivered vector |
| dlv_dest | output | 8 | Destination ID |
| dlv_dest_mode | output | 1 | 1 = logical destination, 0 = physical |
| dlv_mode | output | 3 | Delivery mode |
| dlv_level | output | 1 | 1 = level-triggered, 0 = edge |

## Verification
The assertions assume two things about the routing table. First, an entry does not change while its own delivery is waiting for `dlv_ready`. Second, a pulse on `route_rewr` accompanies every edit of an entry's low half. The stimulus respects both: it changes entries only while the output port is idle, and it issues rewrite strobes as single-cycle pulses. EOIs are likewise single-cycle pulses. The one deliberate collision between an EOI and an acceptance is lined up on one known clock edge, so that the precedence rule is exercised exactly.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    parameter int VEC_W  = 8;
    parameter int DEST_W = 8;
    parameter int MODE_W = 3;

    localparam int ENTRY_W = DEST_W + 4 + MODE_W + VEC_W;

    // Routing entry layout, MSB first.
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              level;
        logic              act_low;
        logic              dest_logical;
        logic [MODE_W-1:0] dmode;
        logic [VEC_W-1:0]  vector;
    } route_t;

    // Message presented on the delivery port.
    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [DEST_W-1:0] dest;
        logic              dest_logical;
        logic [MODE_W-1:0] dmode;
        logic              level;
    } dlv_msg_t;

    function automatic dlv_msg_t to_msg(input route_t r);
        dlv_msg_t m;
        m.vector       = r.vector;
        m.dest         = r.dest;
        m.dest_logical = r.dest_logical;
        m.dmode        = r.dmode;
        m.level        = r.level;
        return m;
    endfunction

endpackage

// File: rtl/irq_pin_slice.sv
module irq_pin_slice
    import irq_accept_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pin_raw,
    input  route_t             ent,
    input  logic               rewr,
    input  logic               eoi_valid,
    input  logic [VEC_W-1:0]   eoi_vector,
    input  logic               accept,
    input  logic               in_flight,
    output logic               need
);

    logic eff;
    logic irr;
    logic edge_pend;
    logic rp;
    logic eoi_hit;

    assign eff     = pin_raw ^ ent.act_low;
    assign eoi_hit = eoi_valid && (eoi_vector == ent.vector);

    always_ff @(posedge clk) begin
        if (rst) begin
            irr       <= 1'b0;
            edge_pend <= 1'b0;
            rp        <= 1'b0;
        end else begin
            irr       <= eff;
            edge_pend <= !ent.level && !ent.mask &&
                         ((edge_pend && !accept) || (eff && !irr));
            if (accept && ent.level)
                rp <= 1'b1;
            else if ((eoi_hit && ent.level) || rewr)
                rp <= 1'b0;
        end
    end

    always_comb begin
        need = 1'b0;
        if (!in_flight && !ent.mask)
            need = ent.level ? (irr && !rp) : edge_pend;
    end

    // R4: an accepted level delivery leaves the entry blocked
    p_rp_after_accept_r4: assert property (@(posedge clk) disable iff (rst)
        accept && ent.level |=> rp);

    // R4: a blocked level entry never asks for delivery
    p_level_blocked_r4: assert property (@(posedge clk) disable iff (rst)
        rp && ent.level |-> !need);

    // R6: a matching EOI releases the entry unless acceptance coincides
    p_eoi_release_r6: assert property (@(posedge clk) disable iff (rst)
        eoi_hit && ent.level && !accept |=> !rp);

    // R10: acceptance outranks a simultaneous EOI
    p_accept_wins_r10: assert property (@(posedge clk) disable iff (rst)
        eoi_hit && accept && ent.level |=> rp);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 24,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  need,
    output logic          valid,
    output logic [IW-1:0] idx
);

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (need[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // R8: the pick is a requesting pin and no lower pin is requesting
    p_pick_lowest_r8: assert property (@(posedge clk) disable iff (rst)
        valid |-> need[idx] && ((need & ((N'(1) << idx) - N'(1))) == '0));

    p_pick_any_r8: assert property (@(posedge clk) disable iff (rst)
        (need != '0) |-> valid);

endmodule

// File: rtl/irq_deliv_reg.sv
module irq_deliv_reg
    import irq_accept_pkg::*;
#(
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pick_valid,
    input  logic [IW-1:0] pick_idx,
    input  dlv_msg_t      pick_msg,
    input  logic          ready,
    output logic          valid,
    output dlv_msg_t      msg,
    output logic [IW-1:0] cur_pin
);

    logic take;
    assign take = !valid || ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            msg     <= '0;
            cur_pin <= '0;
        end else if (take) begin
            valid <= pick_valid;
            if (pick_valid) begin
                msg     <= pick_msg;
                cur_pin <= pick_idx;
            end
        end
    end

    // R9: a stalled message neither drops nor changes
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(msg) && $stable(cur_pin));

endmodule

// File: rtl/irq_accept_eoi.sv
module irq_accept_eoi
    import irq_accept_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PINS-1:0]           pin_in,
    input  logic [NUM_PINS*ENTRY_W-1:0]   route_tbl,
    input  logic [NUM_PINS-1:0]           route_rewr,
    input  logic                          eoi_valid,
    input  logic [VEC_W-1:0]              eoi_vector,
    output logic                          dlv_valid,
    input  logic                          dlv_ready,
    output logic [VEC_W-1:0]              dlv_vector,
    output logic [DEST_W-1:0]             dlv_dest,
    output logic                          dlv_dest_mode,
    output logic [MODE_W-1:0]             dlv_mode,
    output logic                          dlv_level
);

    localparam int PIN_W = $clog2(NUM_PINS);

    route_t              ents [NUM_PINS];
    logic [NUM_PINS-1:0] need;
    logic                pick_valid;
    logic [PIN_W-1:0]    pick_idx;
    logic [PIN_W-1:0]    cur_pin;
    dlv_msg_t            out_msg;
    dlv_msg_t            pick_msg;
    logic                acc;

    assign acc = dlv_valid && dlv_ready;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic hit;
        assign ents[i] = route_t'(route_tbl[i*ENTRY_W +: ENTRY_W]);
        assign hit     = dlv_valid && (cur_pin == PIN_W'(i));

        irq_pin_slice u_slice (
            .clk        (clk),
            .rst        (rst),
            .pin_raw    (pin_in[i]),
            .ent        (ents[i]),
            .rewr       (route_rewr[i]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .accept     (hit && acc),
            .in_flight  (hit),
            .need       (need[i])
        );
    end

    irq_prio_pick #(.N(NUM_PINS), .IW(PIN_W)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .need  (need),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    assign pick_msg = to_msg(ents[pick_idx]);

    irq_deliv_reg #(.IW(PIN_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .pick_msg   (pick_msg),
        .ready      (dlv_ready),
        .valid      (dlv_valid),
        .msg        (out_msg),
        .cur_pin    (cur_pin)
    );

    assign dlv_vector    = out_msg.vector;
    assign dlv_dest      = out_msg.dest;
    assign dlv_dest_mode = out_msg.dest_logical;
    assign dlv_mode      = out_msg.dmode;
    assign dlv_level     = out_msg.level;

    // R5: the picker never selects a masked entry
    p_pick_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
        pick_valid |-> !ents[pick_idx].mask);

    // R1: nothing is offered in the first cycle out of reset
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !dlv_valid);

endmodule

// File: tb/irq_accept_eoi_test.sv
module irq_accept_eoi_test;
    import irq_accept_pkg::*;

    localparam int N  = 24;
    localparam int EW = ENTRY_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    pins;
    logic [N*EW-1:0] tbl;
    logic [N-1:0]    rewr;
    logic            eoi_v;
    logic [7:0]      eoi_vec;
    logic            rdy;
    logic            dlv_valid;
    logic [7:0]      dlv_vector;
    logic [7:0]      dlv_dest;
    logic            dlv_dest_mode;
    logic [2:0]      dlv_mode;
    logic            dlv_level;

    int checks = 0;
    int fails  = 0;
    logic [20:0] expq [$];
    string       tagq [$];

    always #2.5 clk = ~clk;

    irq_accept_eoi #(.NUM_PINS(N)) uut (
        .clk(clk), .rst(rst), .pin_in(pins), .route_tbl(tbl),
        .route_rewr(rewr), .eoi_valid(eoi_v), .eoi_vector(eoi_vec),
        .dlv_valid(dlv_valid), .dlv_ready(rdy), .dlv_vector(dlv_vector),
        .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode),
        .dlv_mode(dlv_mode), .dlv_level(dlv_level)
    );

    function automatic logic [22:0] mk(input logic [7:0] v, input logic [7:0] d,
                                       input logic dm, input logic [2:0] md,
                                       input logic pol, input logic lvl,
                                       input logic msk);
        return {d, msk, lvl, pol, dm, md, v};
    endfunction

    task automatic set_ent(input int i, input logic [22:0] e);
        tbl[i*EW +: EW] = e;
    endtask

    task automatic push(input string tag, input logic [7:0] v, input logic [7:0] d,
                        input logic dm, input logic [2:0] md, input logic lvl);
        expq.push_back({v, d, dm, md, lvl});
        tagq.push_back(tag);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drain(input string tag);
        step(8);
        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d deliveries outstanding, expected 0", tag, expq.size());
            expq.delete();
            tagq.delete();
        end
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_v = 1'b1; eoi_vec = v;
        step(1);
        eoi_v = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && dlv_valid && rdy) begin
            logic [20:0] got;
            got = {dlv_vector, dlv_dest, dlv_dest_mode, dlv_mode, dlv_level};
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL unexpected delivery: actual %h expected none", got);
            end else begin
                logic [20:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                if (got !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, got, e);
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        pins = '0; pins[5] = 1'b1;
        rewr = '0; eoi_v = 1'b0; eoi_vec = '0; rdy = 1'b1;
        for (int i = 0; i < N; i++) set_ent(i, mk(8'h00, 8'h00, 0, 3'd0, 0, 0, 1));
        set_ent(3, mk(8'h31, 8'h03, 0, 3'd0, 0, 0, 0));
        set_ent(5, mk(8'h52, 8'h15, 1, 3'd1, 1, 0, 0));
        set_ent(7, mk(8'h77, 8'h27, 0, 3'd0, 0, 1, 0));
        set_ent(9, mk(8'h99, 8'h09, 0, 3'd0, 0, 1, 1));
        set_ent(2, mk(8'h22, 8'h02, 0, 3'd2, 0, 0, 0));
        set_ent(4, mk(8'h44, 8'h04, 1, 3'd4, 0, 0, 0));
        step(3);
        rst = 1'b0;
        step(1);
        checks++;
        if (dlv_valid !== 1'b0) begin
            fails++; $display("FAIL R1: valid actual %b expected 0", dlv_valid);
        end
        drain("R1");

        // R3: edge pin fires once, holding gives nothing more
        pins[3] = 1'b1;
        push("R3", 8'h31, 8'h03, 0, 3'd0, 0);
        drain("R3");
        step(10);
        drain("R3 held");
        pins[3] = 1'b0; step(2);
        pins[3] = 1'b1;
        push("R3 re-rise", 8'h31, 8'h03, 0, 3'd0, 0);
        drain("R3 re-rise");

        // R2: active-low pin
        pins[5] = 1'b0;
        push("R2", 8'h52, 8'h15, 1, 3'd1, 0);
        drain("R2");
        pins[5] = 1'b1;
        drain("R2 inactive");

        // R4: level pin delivered once, then blocked
        pins[7] = 1'b1;
        push("R4", 8'h77, 8'h27, 0, 3'd0, 1);
        drain("R4");

        // R6: EOI behaviour
        eoi(8'h31);
        drain("R6 other vector");
        eoi(8'h77);
        push("R6 redeliver", 8'h77, 8'h27, 0, 3'd0, 1);
        drain("R6 redeliver");
        pins[7] = 1'b0; step(2);
        eoi(8'h77);
        drain("R6 line low");
        pins[7] = 1'b1;
        push("R6 after release", 8'h77, 8'h27, 0, 3'd0, 1);
        drain("R6 after release");

        // R7: rewrite strobe releases the entry
        rewr[7] = 1'b1; step(1); rewr[7] = 1'b0;
        push("R7", 8'h77, 8'h27, 0, 3'd0, 1);
        drain("R7");

        // R5: masked level request is kept, delivered after unmask
        pins[9] = 1'b1;
        drain("R5 masked");
        set_ent(9, mk(8'h99, 8'h09, 0, 3'd0, 0, 1, 0));
        push("R5 unmask", 8'h99, 8'h09, 0, 3'd0, 1);
        drain("R5 unmask");

        // R10: EOI coincides with acceptance
        rdy = 1'b0;
        eoi(8'h77);
        push("R10", 8'h77, 8'h27, 0, 3'd0, 1);
        step(3);
        rdy = 1'b1; eoi_v = 1'b1; eoi_vec = 8'h77;
        step(1);
        eoi_v = 1'b0;
        drain("R10 no redelivery");
        eoi(8'h77);
        push("R10 later EOI", 8'h77, 8'h27, 0, 3'd0, 1);
        drain("R10 later EOI");

        // R8 / R9: two pins together under stall
        rdy = 1'b0;
        pins[2] = 1'b1; pins[4] = 1'b1;
        push("R8 first", 8'h22, 8'h02, 0, 3'd2, 0);
        push("R8 second", 8'h44, 8'h04, 1, 3'd4, 0);
        step(3);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            checks++;
            if (!(dlv_valid && dlv_vector == 8'h22 && dlv_dest == 8'h02)) begin
                fails++;
                $display("FAIL R9: actual valid %b vec %h expected 1 22",
                         dlv_valid, dlv_vector);
            end
        end
        @(posedge clk); #1;
        rdy = 1'b1;
        drain("R8");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule